// File: doc/BRIEF.md
# Per-CPU interrupt level combiner

This block is the local interrupt unit of one processor. It holds a 32-bit pending word. Software reaches that word through a four-word register window, where one index reads it, one clears bits in it and one sets bits in it. The block merges four kinds of request into fifteen registered interrupt-level lines, numbered 15 down to 1:

- soft requests, held in the upper half of the pending word;
- a per-CPU timer input;
- a shared level-15 input;
- a hard-level vector from the system interrupt router, used when this CPU is the selected target.

A global master-disable input suppresses the timer path, the level-15 path and the hard-level path. Soft requests are never masked.

The router supplies two vectors. The first carries only the enabled hard levels, and those drive the outputs. The second carries every pending hard level, whether enabled or not, and it is mirrored into the low bits of the pending word for inspection. Next to the level lines, the block gives a 4-bit number: the highest active level, or 0 when no line is active.

Top module: `cpu_level_combiner`

## Requirements
- R1: The window is decoded on word index (byte address bits [3:2]). A read at index 0 returns the pending word. A read at any other index returns 0.
- R2: A write at index 1 clears pending bits. The write data is first masked with 0xFFFE8000, so only soft bits 31:17 and bit 15 can be cleared.
- R3: A write at index 2 sets pending bits. The write data is first masked with 0xFFFE0000, so only bits 31:17 can be set, and bits 16:0 stay unchanged.
- R4: Pending bit 14 follows the timer input, one clock later. Software writes cannot change it.
- R5: Pending bit 15 is set on a rising edge of the level-15 input and cleared on a falling edge. It can also be cleared through the clear index.
- R6: Pending bits 15 and 14 drive level lines 15 and 14 only while master-disable is low.
- R7: Soft bit k (17 to 31) drives level line k-16 regardless of master-disable.
- R8: The enabled hard-level vector drives the level lines only while this CPU is the target and master-disable is low.
- R9: Pending bits 13:1 show the all-pending hard-level vector while this CPU is the target, whatever master-disable is, and read 0 while it is not. Pending bits 0 and 16 always read 0.
- R10: While reset is asserted, the pending word, every level line and the highest-level output are 0.
- R11: The level lines and the pending word change at the first rising clock edge after a write or an input change. There is no level line 0.
- R12: The highest-level output gives the number of the highest active level line as a 4-bit value, and 0 when no line is active.
- R13: Only full-word accesses (all four byte enables set) take effect. A partial write changes nothing, and a partial read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Byte address into the window |
| busRd | input | 1 | Read request |
| busWr | input | 1 | Write request |
| busByteEn | input | 4 | Byte enables; only 4'hF is accepted |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| timerIn | input | 1 | Per-CPU timer request |
| lvl15In | input | 1 | Shared level-15 request |
| masterDisable | input | 1 | Global disable for the timer, level-15 and hard-level paths |
| isTarget | input | 1 | This CPU is the selected target for routed sources |
| hardLevels | input | 15 | Enabled hard levels 15:1 from the router |
| rawLevels | input | 15 | All pending hard levels 15:1, for display |
| levelOut | output | 15 | Registered interrupt-level lines 15:1 |
| highLevel | output | 4 | Highest active level, 0 when none |

## Verification
Every write, timer change, level-15 edge, target change or disable change is due at both the level lines and the pending word at the first rising edge after the stimulus is applied. The highest-level number and the read data follow from those registers without further delay. The bench drives stimulus just after a falling edge and queues the expected pending word and level vector, tagged with the cycle count of the next rising edge. A monitor pops each entry at the falling edge after that rising edge and compares it there. Reads of the non-pending indices, partial reads and the reset state are checked within a single low clock phase, because the read path has no register.

// File: rtl/lvl_comb_pkg.sv
package lvl_comb_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int WORD_W    = 32;
  localparam int NUM_LVL   = 15;
  localparam int LVL_W     = 4;
  localparam int SOFT_LSB  = 17;
  localparam int TIMER_BIT = 14;
  localparam int L15_BIT   = 15;
  localparam int DISP_HI   = 13;
  localparam int IDX_PEND  = 0;
  localparam int IDX_CLR   = 1;
  localparam int IDX_SET   = 2;

  localparam logic [WORD_W-1:0] CLR_MASK = 32'hFFFE_8000;
  localparam logic [WORD_W-1:0] SET_MASK = 32'hFFFE_0000;

  typedef struct packed {
    logic              clrStb;
    logic              setStb;
    logic              rdStb;
    logic [WORD_W-1:0] data;
  } winCmd_t;
endpackage

// File: rtl/lvl_comb_ctrl.sv
module lvl_comb_ctrl
  import lvl_comb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [3:0]        busByteEn,
  input  logic [WORD_W-1:0] busWdata,
  output winCmd_t           cmd
);
  timeunit 1ns; timeprecision 100ps;

  localparam int IDX_W = ADDR_W - 2;

  logic             fullWord;
  logic [IDX_W-1:0] wordIdx;

  always_comb begin
    fullWord   = (busByteEn == 4'hF);
    wordIdx    = busAddr[ADDR_W-1:2];
    cmd.clrStb = busWr && fullWord && (wordIdx == IDX_W'(IDX_CLR));
    cmd.setStb = busWr && fullWord && (wordIdx == IDX_W'(IDX_SET));
    cmd.rdStb  = busRd && fullWord && (wordIdx == IDX_W'(IDX_PEND));
    if (cmd.clrStb)      cmd.data = busWdata & CLR_MASK;
    else if (cmd.setStb) cmd.data = busWdata & SET_MASK;
    else                 cmd.data = '0;
  end

  // R13: a partial write produces no strobe
  assert_partial_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busByteEn != 4'hF) |-> (!cmd.clrStb && !cmd.setStb));

  // R3: a set strobe never carries bits below the soft field
  assert_set_low_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setStb |-> (cmd.data[SOFT_LSB-1:0] == '0));
endmodule

// File: rtl/lvl_comb_dp.sv
module lvl_comb_dp
  import lvl_comb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  winCmd_t           cmd,
  input  logic              timerIn,
  input  logic              lvl15In,
  input  logic              masterDisable,
  input  logic              isTarget,
  input  logic [NUM_LVL:1]  hardLevels,
  input  logic [NUM_LVL:1]  rawLevels,
  output logic [WORD_W-1:0] rdData,
  output logic [NUM_LVL:1]  levelOut,
  output logic [LVL_W-1:0]  highLevel
);
  timeunit 1ns; timeprecision 100ps;

  logic [WORD_W-1:0] pendQ, pendD;
  logic              l15Prev;
  logic [NUM_LVL:1]  levelQ, levelD;
  logic [NUM_LVL:1]  bypassLv, hardLv;

  // next pending word: software first, then hardware-owned bits
  always_comb begin
    pendD = pendQ;
    if (cmd.setStb) pendD = pendD | cmd.data;
    if (cmd.clrStb) pendD = pendD & ~cmd.data;
    pendD[TIMER_BIT] = timerIn;
    if (lvl15In && !l15Prev)      pendD[L15_BIT] = 1'b1;
    else if (!lvl15In && l15Prev) pendD[L15_BIT] = 1'b0;
    pendD[DISP_HI:1] = isTarget ? rawLevels[DISP_HI:1] : '0;
    pendD[SOFT_LSB-1] = 1'b0;
    pendD[0]          = 1'b0;
  end

  // next level vector from the next pending word
  always_comb begin
    bypassLv = '0;
    if (!masterDisable) begin
      bypassLv[L15_BIT]   = pendD[L15_BIT];
      bypassLv[TIMER_BIT] = pendD[TIMER_BIT];
    end
    hardLv = (isTarget && !masterDisable) ? hardLevels : '0;
    levelD = pendD[WORD_W-1:SOFT_LSB] | bypassLv | hardLv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      l15Prev <= 1'b0;
      levelQ  <= '0;
    end else begin
      pendQ   <= pendD;
      l15Prev <= lvl15In;
      levelQ  <= levelD;
    end
  end

  always_comb begin
    highLevel = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (levelQ[i]) highLevel = LVL_W'(i);
    end
  end

  assign rdData   = cmd.rdStb ? pendQ : '0;
  assign levelOut = levelQ;

  // R4: pending bit 14 tracks the timer input one clock later
  assert_timer_track_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendQ[TIMER_BIT] == $past(timerIn)));

  // R5: a rising level-15 input is latched into bit 15
  assert_l15_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lvl15In) |=> pendQ[L15_BIT]);

  // R2: a clear strobe removes the addressed soft bit
  assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clrStb && cmd.data[20]) |=> !pendQ[20]);

  // R7: setting soft bit 31 raises level 15
  assert_soft_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setStb && cmd.data[WORD_W-1]) |=> levelOut[NUM_LVL]);

  // R6: with master-disable held and no other source for line 14, it stays low
  assert_bypass_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterDisable && !isTarget && !pendD[SOFT_LSB+TIMER_BIT-1]) |=> !levelOut[TIMER_BIT]);
endmodule

// File: rtl/cpu_level_combiner.sv
module cpu_level_combiner
  import lvl_comb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              timerIn,
  input  logic              lvl15In,
  input  logic              masterDisable,
  input  logic              isTarget,
  input  logic [15:1]       hardLevels,
  input  logic [15:1]       rawLevels,
  output logic [15:1]       levelOut,
  output logic [3:0]        highLevel
);
  timeunit 1ns; timeprecision 100ps;

  winCmd_t cmd;

  lvl_comb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .cmd       (cmd)
  );

  lvl_comb_dp u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .timerIn       (timerIn),
    .lvl15In       (lvl15In),
    .masterDisable (masterDisable),
    .isTarget      (isTarget),
    .hardLevels    (hardLevels),
    .rawLevels     (rawLevels),
    .rdData        (busRdata),
    .levelOut      (levelOut),
    .highLevel     (highLevel)
  );

  // R12: no active line means the encoded level is zero
  assert_idle_code_R12: assert property (@(posedge clk) disable iff (!rstN)
    (levelOut == '0) |-> (highLevel == '0));
endmodule

// File: tb/cpu_level_combiner_tb.sv
module cpu_level_combiner_tb;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr;
  logic        busRd, busWr;
  logic [3:0]  busByteEn;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        timerIn, lvl15In, masterDisable, isTarget;
  logic [15:0] hardV, rawV;
  logic [15:1] levelOut;
  logic [3:0]  highLevel;

  cpu_level_combiner u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .timerIn(timerIn), .lvl15In(lvl15In), .masterDisable(masterDisable),
    .isTarget(isTarget), .hardLevels(hardV[15:1]), .rawLevels(rawV[15:1]),
    .levelOut(levelOut), .highLevel(highLevel)
  );

  always #2 clk = ~clk;

  int cycleCnt = 0;
  always @(posedge clk) cycleCnt++;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] pend;
    logic [15:0] lvl;
    string       req;
  } expItem_t;
  expItem_t sbq[$];

  function automatic logic [3:0] topLevel(logic [15:0] v);
    for (int i = 15; i >= 1; i--) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // monitor: compare queued expectations once their edge has passed
  always @(negedge clk) begin
    expItem_t it;
    while (sbq.size() > 0 && sbq[0].due <= cycleCnt) begin
      it = sbq.pop_front();
      check32(it.req, "pending", busRdata, it.pend);
      check32(it.req, "levels", {16'd0, levelOut, 1'b0}, {16'd0, it.lvl});
      check32(it.req, "highLevel", {28'd0, highLevel}, {28'd0, topLevel(it.lvl)});
    end
  end

  task automatic idleBus();
    busAddr = 4'd0; busRd = 1'b1; busWr = 1'b0; busByteEn = 4'hF; busWdata = '0;
  endtask

  task automatic sync();
    @(negedge clk); #0.2;
  endtask

  task automatic wr(int idx, logic [3:0] be, logic [31:0] data);
    busAddr = {idx[1:0], 2'b00}; busRd = 1'b0; busWr = 1'b1;
    busByteEn = be; busWdata = data;
  endtask

  task automatic expectNext(logic [31:0] ePend, logic [15:0] eLvl, string req);
    expItem_t it;
    it.due = cycleCnt + 1; it.pend = ePend; it.lvl = eLvl; it.req = req;
    sbq.push_back(it);
    @(posedge clk); #0.2;
    idleBus();
  endtask

  task automatic readCheck(int idx, logic [3:0] be, logic [31:0] exp, string req);
    sync();
    busAddr = {idx[1:0], 2'b00}; busRd = 1'b1; busWr = 1'b0; busByteEn = be;
    #0.5;
    check32(req, "read", busRdata, exp);
    idleBus();
  endtask

  initial begin
    idleBus();
    timerIn = 0; lvl15In = 0; masterDisable = 0; isTarget = 0; hardV = '0; rawV = '0;
    repeat (3) @(negedge clk);
    #0.5;
    // R10: state under reset
    check32("R10", "pending", busRdata, 32'h0);
    check32("R10", "levels", {16'd0, levelOut, 1'b0}, 32'h0);
    check32("R10", "highLevel", {28'd0, highLevel}, 32'h0);
    sync(); rstN = 1'b1;

    sync(); wr(2, 4'hF, 32'hFFFF_FFFF); expectNext(32'hFFFE_0000, 16'hFFFE, "R3 R7 R12");
    sync(); wr(1, 4'hF, 32'hFFFF_FFFF); expectNext(32'h0, 16'h0, "R2");
    sync(); wr(2, 4'hF, 32'h0002_0000); expectNext(32'h0002_0000, 16'h0002, "R7 R11");
    sync(); wr(2, 4'hF, 32'h0040_0000); expectNext(32'h0042_0000, 16'h0042, "R7 R12");
    sync(); wr(2, 4'h3, 32'h8000_0000); expectNext(32'h0042_0000, 16'h0042, "R13");
    sync(); wr(3, 4'hF, 32'hFFFF_FFFF); expectNext(32'h0042_0000, 16'h0042, "R1");
    sync(); wr(2, 4'hF, 32'h0001_4000); expectNext(32'h0042_0000, 16'h0042, "R3");
    sync(); timerIn = 1; expectNext(32'h0042_4000, 16'h4042, "R4 R6");
    sync(); masterDisable = 1; expectNext(32'h0042_4000, 16'h0042, "R6");
    sync(); lvl15In = 1; expectNext(32'h0042_C000, 16'h0042, "R5 R6");
    sync(); masterDisable = 0; expectNext(32'h0042_C000, 16'hC042, "R6 R12");
    sync(); wr(1, 4'hF, 32'h0000_C000); expectNext(32'h0042_4000, 16'h4042, "R2 R5");
    sync(); lvl15In = 0; timerIn = 0; expectNext(32'h0042_0000, 16'h0042, "R4");
    sync(); lvl15In = 1; expectNext(32'h0042_8000, 16'h8042, "R5");
    sync(); lvl15In = 0; expectNext(32'h0042_0000, 16'h0042, "R5");
    sync(); hardV = 16'h0008; rawV = 16'h0028; expectNext(32'h0042_0000, 16'h0042, "R8 R9");
    sync(); isTarget = 1; expectNext(32'h0042_0028, 16'h004A, "R8 R9");
    sync(); masterDisable = 1; expectNext(32'h0042_0028, 16'h0042, "R8 R9");
    sync(); masterDisable = 0; hardV = 16'h2000; rawV = 16'h2000;
    expectNext(32'h0042_2000, 16'h2042, "R8 R12");
    sync(); isTarget = 0; expectNext(32'h0042_0000, 16'h0042, "R9");

    readCheck(3, 4'hF, 32'h0, "R1");
    readCheck(1, 4'hF, 32'h0, "R1");
    readCheck(0, 4'h1, 32'h0, "R13");
    readCheck(0, 4'hF, 32'h0042_0000, "R1");

    // reset in the middle of activity
    sync(); rstN = 1'b0; hardV = '0; rawV = '0;
    #0.5;
    check32("R10", "pending", busRdata, 32'h0);
    check32("R10", "levels", {16'd0, levelOut, 1'b0}, 32'h0);
    sync(); rstN = 1'b1;
    sync(); wr(2, 4'hF, 32'h8000_0000); expectNext(32'h8000_0000, 16'h8000, "R7 R10");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog all R: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule